// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block produces the serial-clock timing that an I2C master engine drives onto the bus. A prescaler divides the peripheral clock by one plus a small prescale field to give an internal tick. The SCL period is then counted in those ticks. The low phase and the high phase each take half of a base length of 20 + 8·S ticks, where S is a six-bit division field. Any odd tick would go to the low phase.

When the low phase ends, the divider releases SCL. It then waits until the line is sensed high before it counts the high phase. A slow rise or a slave holding the clock low therefore stretches the period automatically. The engine sees one-cycle strobes at the start of each phase, a tick strobe, and a level that shows it is waiting for the rise.

The divider setting is a single word with the division field packed above the prescale field. The prescale field width is a parameter of 2 or 3 bits. A new setting is sampled only while the block is disabled, or at the boundary where a high phase hands over to the next low phase. Clearing the enable releases SCL and returns every counter to its rest state.

Top module: `sclClockDivider`

## Requirements
- R1: After reset, and in every cycle after a cycle sampled with `enable` low, `sclOut` is 1 (released) and `ickTick`, `lowStart`, `highStart` and `riseWait` are all 0.
- R2: The prescale field P is `divCfg[CDF_W-1:0]`. During a counted phase (low or high), `ickTick` pulses once every P+1 clocks, on the last clock of each group. The count restarts at the start of each phase.
- R3: The division field S is `divCfg[CDF_W+5:CDF_W]`. The low phase (`sclOut` = 0) lasts ceil((20+8·S)/2)·(P+1) clocks.
- R4: The high phase lasts floor((20+8·S)/2)·(P+1) clocks. Its counting starts only on the clock after `sclIn` is sampled high.
- R5: Between the low and high phases, `riseWait` is 1 with `sclOut` = 1 for as long as `sclIn` stays 0. When `sclIn` is already high, this wait lasts exactly one clock.
- R6: `divCfg` is sampled while idle, and when a high phase ends with `enable` still 1. A change made during a period has no effect until the next low phase.
- R7: `lowStart` is 1 only in the first clock of each low phase, and `highStart` only in the first clock of each high phase. The two are never 1 together.
- R8: Dropping `enable` in the middle of any phase returns the block to idle on the next clock. Raising `enable` again starts a fresh low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Master interface enable; 0 holds the divider idle |
| divCfg | input | CDF_W+SCGD_W | Divider setting: division field above prescale field |
| sclIn | input | 1 | Sensed level of the SCL line (already synchronous) |
| ickTick | output | 1 | Internal-clock enable strobe during counted phases |
| sclOut | output | 1 | SCL drive: 0 pulls low, 1 releases |
| lowStart | output | 1 | Pulse in the first clock of a low phase |
| highStart | output | 1 | Pulse in the first clock of a high phase |
| riseWait | output | 1 | SCL released but not yet sensed high |

## Verification
The bench goes after four timing corners.

- Slow rises: it delays the emulated SCL rise by several clocks. A divider that counted the high phase from the release instead of from the sensed edge would shorten the high time by that delay.
- Setting changes mid-period: it rewrites the setting in the middle of a low phase. A design that sampled it continuously would show a wrong low or high length in the current period.
- Prescale above zero: it uses a nonzero prescale value, which exposes a prescaler that does not restart at phase edges. The tick strobe would then drift against the reference.
- Disable during a phase: it drops the enable mid-phase. A design that finished the phase first would keep SCL low one or more clocks too long.

// File: rtl/sclDivPkg.sv
package sclDivPkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic countEn;   // a counted phase is running
    logic phaseLow;  // select low-phase length
    logic clrCnt;    // restart prescaler and tick counter
    logic loadCfg;   // capture a new divider setting
  } divCtl_t;

endpackage

// File: rtl/sclDivData.sv
module sclDivData
  import sclDivPkg::*;
#(
  parameter int CDF_W  = 3,
  parameter int SCGD_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CDF_W+SCGD_W-1:0] divCfg,
  input  divCtl_t                 ctl,
  output logic                    ickTick,
  output logic                    phaseDone
);
  localparam int CFG_W  = CDF_W + SCGD_W;
  localparam int BASE_W = SCGD_W + 4;
  localparam int CNT_W  = BASE_W - 1;

  logic [CFG_W-1:0]  cfgQ;
  logic [CDF_W-1:0]  preCnt;
  logic [CNT_W-1:0]  tickCnt;
  logic [CDF_W-1:0]  cdfVal;
  logic [SCGD_W-1:0] scgdVal;
  logic [BASE_W-1:0] baseLen;
  logic [BASE_W-1:0] baseUp;
  logic [CNT_W-1:0]  lowLen;
  logic [CNT_W-1:0]  highLen;
  logic [CNT_W-1:0]  lastCnt;

  assign cdfVal  = cfgQ[CDF_W-1:0];
  assign scgdVal = cfgQ[CFG_W-1:CDF_W];

  // base period 20 + 8*S ticks, split with odd tick to low phase
  assign baseLen = BASE_W'(20) + BASE_W'({scgdVal, 3'b000});
  assign baseUp  = baseLen + BASE_W'(1);
  assign lowLen  = baseUp[BASE_W-1:1];
  assign highLen = baseLen[BASE_W-1:1];
  assign lastCnt = ctl.phaseLow ? (lowLen - CNT_W'(1)) : (highLen - CNT_W'(1));

  assign ickTick   = ctl.countEn && (preCnt == cdfVal);
  assign phaseDone = ickTick && (tickCnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (ctl.loadCfg) begin
      cfgQ <= divCfg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (ctl.clrCnt) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (ctl.countEn) begin
      preCnt <= ickTick ? '0 : preCnt + CDF_W'(1);
      if (ickTick) begin
        tickCnt <= tickCnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sclDivCtrl.sv
module sclDivCtrl
  import sclDivPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    sclIn,
  input  logic    phaseDone,
  output divCtl_t ctl,
  output logic    sclOut,
  output logic    riseWait,
  output logic    lowStart,
  output logic    highStart
);
  phase_e phase;
  phase_e phaseNext;

  always_comb begin
    phaseNext = phase;
    if (!enable) begin
      phaseNext = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: phaseNext = PH_LOW;
        PH_LOW:  if (phaseDone) phaseNext = PH_WAIT;
        PH_WAIT: if (sclIn) phaseNext = PH_HIGH;
        PH_HIGH: if (phaseDone) phaseNext = PH_LOW;
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.countEn  = enable && ((phase == PH_LOW) || (phase == PH_HIGH));
    ctl.phaseLow = (phase == PH_LOW);
    ctl.clrCnt   = !ctl.countEn || phaseDone;
    ctl.loadCfg  = (phase == PH_IDLE) || ((phase == PH_HIGH) && phaseDone);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      lowStart  <= 1'b0;
      highStart <= 1'b0;
    end else begin
      phase     <= phaseNext;
      lowStart  <= (phaseNext == PH_LOW) && (phase != PH_LOW);
      highStart <= (phaseNext == PH_HIGH) && (phase != PH_HIGH);
    end
  end

  assign sclOut   = (phase != PH_LOW);
  assign riseWait = (phase == PH_WAIT);

endmodule

// File: rtl/sclClockDivider.sv
module sclClockDivider
  import sclDivPkg::*;
#(
  parameter int CDF_W  = 3,
  parameter int SCGD_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic [CDF_W+SCGD_W-1:0] divCfg,
  input  logic                    sclIn,
  output logic                    ickTick,
  output logic                    sclOut,
  output logic                    lowStart,
  output logic                    highStart,
  output logic                    riseWait
);
  divCtl_t ctl;
  logic    phaseDone;

  sclDivCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .sclIn     (sclIn),
    .phaseDone (phaseDone),
    .ctl       (ctl),
    .sclOut    (sclOut),
    .riseWait  (riseWait),
    .lowStart  (lowStart),
    .highStart (highStart)
  );

  sclDivData #(
    .CDF_W  (CDF_W),
    .SCGD_W (SCGD_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .divCfg    (divCfg),
    .ctl       (ctl),
    .ickTick   (ickTick),
    .phaseDone (phaseDone)
  );

endmodule

// File: rtl/sclClockDivider_chk.sv
module sclClockDivider_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclIn,
  input logic ickTick,
  input logic sclOut,
  input logic lowStart,
  input logic highStart,
  input logic riseWait
);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclOut && !lowStart && !highStart && !riseWait));

  // R2
  tick_not_waiting_chk: assert property (@(posedge clk) disable iff (!rstN)
    ickTick |-> (enable && !riseWait));

  // R4
  high_after_sense_chk: assert property (@(posedge clk) disable iff (!rstN)
    highStart |-> $past(sclIn));

  // R5
  wait_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (riseWait && !sclIn && enable) |=> riseWait);

  // R7
  low_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowStart |-> (!sclOut && !$past(lowStart)));

  // R7
  start_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lowStart, highStart}));

endmodule

bind sclClockDivider sclClockDivider_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .sclIn     (sclIn),
  .ickTick   (ickTick),
  .sclOut    (sclOut),
  .lowStart  (lowStart),
  .highStart (highStart),
  .riseWait  (riseWait)
);

// File: tb/sclClockDivider_tb_top.sv
`timescale 1ns/1ps
module sclClockDivider_tb_top;
  localparam int CDF_W  = 3;
  localparam int SCGD_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [CDF_W+SCGD_W-1:0] divCfg = '0;
  logic sclIn = 1'b1;
  logic ickTick, sclOut, lowStart, highStart, riseWait;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sclClockDivider #(.CDF_W(CDF_W), .SCGD_W(SCGD_W)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .divCfg(divCfg), .sclIn(sclIn),
    .ickTick(ickTick), .sclOut(sclOut), .lowStart(lowStart),
    .highStart(highStart), .riseWait(riseWait)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowTicks(input int s);
    return (20 + 8 * s + 1) / 2;
  endfunction
  function automatic int highTicks(input int s);
    return (20 + 8 * s) / 2;
  endfunction

  // behavioural reference: 0 idle, 1 low, 2 wait, 3 high
  int mSt = 0, mEl = 0, mCdf = 0, mScgd = 0;
  bit mLowS = 0, mHighS = 0;

  always @(posedge clk) begin
    int nxt;
    bit ld;
    if (!rstN) begin
      mSt = 0; mEl = 0; mCdf = 0; mScgd = 0; mLowS = 0; mHighS = 0;
    end else begin
      nxt = mSt;
      ld = (mSt == 0);
      if (!enable) nxt = 0;
      else if (mSt == 0) nxt = 1;
      else if (mSt == 1) begin
        if (mEl == lowTicks(mScgd) * (mCdf + 1) - 1) nxt = 2;
      end else if (mSt == 2) begin
        if (sclIn) nxt = 3;
      end else begin
        if (mEl == highTicks(mScgd) * (mCdf + 1) - 1) begin nxt = 1; ld = 1; end
      end
      mLowS  = (nxt == 1) && (mSt != 1);
      mHighS = (nxt == 3) && (mSt != 3);
      mEl = ((nxt == mSt) && (mSt == 1 || mSt == 3)) ? mEl + 1 : 0;
      mSt = nxt;
      if (ld) begin
        mCdf  = int'(divCfg[CDF_W-1:0]);
        mScgd = int'(divCfg[CDF_W+SCGD_W-1:CDF_W]);
      end
    end
  end

  // comparison, run-length monitor and emulated SCL line
  int riseDly = 0, relCnt = 0;
  int lowRun = 0, waitRun = 0, highRun = 0;
  int lastLow = 0, lastWait = 0, lastHigh = 0;

  always @(negedge clk) begin
    bit expTick;
    if (rstN && !finished) begin
      expTick = enable && (mSt == 1 || mSt == 3) && ((mEl % (mCdf + 1)) == mCdf);
      chk(sclOut == (mSt != 1), "R3 sclOut", int'(sclOut), int'(mSt != 1));
      chk(riseWait == (mSt == 2), "R5 riseWait", int'(riseWait), int'(mSt == 2));
      chk(ickTick == expTick, "R2 ickTick", int'(ickTick), int'(expTick));
      chk(lowStart == mLowS, "R7 lowStart", int'(lowStart), int'(mLowS));
      chk(highStart == mHighS, "R7 highStart", int'(highStart), int'(mHighS));
    end
    if (!sclOut) begin
      lowRun++;
      if (highRun > 0) begin lastHigh = highRun; highRun = 0; end
    end else begin
      if (lowRun > 0) begin lastLow = lowRun; lowRun = 0; end
      if (riseWait) waitRun++;
      else begin
        if (waitRun > 0) begin lastWait = waitRun; waitRun = 0; end
        highRun++;
      end
    end
    if (!sclOut) begin
      relCnt = 0; sclIn = 1'b0;
    end else begin
      relCnt++;
      sclIn = (relCnt > riseDly);
    end
  end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  function automatic logic [CDF_W+SCGD_W-1:0] mkCfg(input int s, input int p);
    return {SCGD_W'(s), CDF_W'(p)};
  endfunction

  task automatic finish;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    chk(0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    waitCyc(3);
    // R1: reset state
    chk(sclOut == 1 && !ickTick && !lowStart && !highStart && !riseWait,
        "R1 reset outputs", int'({sclOut, ickTick, lowStart, highStart, riseWait}), 16);
    rstN = 1'b1;
    waitCyc(2);

    // fastest setting, immediate rise
    divCfg = mkCfg(0, 0); riseDly = 0;
    enable = 1'b1;
    waitCyc(100);
    chk(lastLow == 10, "R3 low length S=0 P=0", lastLow, 10);
    chk(lastHigh == 10, "R4 high length S=0 P=0", lastHigh, 10);
    chk(lastWait == 1, "R5 single wait clock", lastWait, 1);

    // R1: disabled
    enable = 1'b0;
    waitCyc(2);
    chk(sclOut && !riseWait && !lowStart, "R1 disabled released",
        int'({sclOut, riseWait, lowStart}), 4);

    // prescale 2, S=3, slow rise of 4 extra clocks
    divCfg = mkCfg(3, 2); riseDly = 4;
    enable = 1'b1;
    waitCyc(600);
    chk(lastLow == lowTicks(3) * 3, "R3 low length S=3 P=2", lastLow, lowTicks(3) * 3);
    chk(lastHigh == highTicks(3) * 3, "R4 high length S=3 P=2", lastHigh, highTicks(3) * 3);
    chk(lastWait == 5, "R5 stretched wait", lastWait, 5);

    // R6: change setting during a low phase
    while (!lowStart) waitCyc(1);
    waitCyc(5);
    divCfg = mkCfg(1, 0);
    while (!sclOut) waitCyc(1);
    chk(lastLow == lowTicks(3) * 3, "R6 current low unchanged", lastLow, lowTicks(3) * 3);
    while (sclOut) waitCyc(1);
    chk(lastHigh == highTicks(3) * 3, "R6 current high unchanged", lastHigh, highTicks(3) * 3);
    while (!sclOut) waitCyc(1);
    chk(lastLow == lowTicks(1), "R6 next low uses new setting", lastLow, lowTicks(1));

    // R8: disable mid low phase
    while (!lowStart) waitCyc(1);
    waitCyc(4);
    enable = 1'b0;
    waitCyc(1);
    chk(sclOut == 1'b1, "R8 released next clock", int'(sclOut), 1);
    chk(!ickTick && !riseWait, "R8 idle after disable", int'({ickTick, riseWait}), 0);
    divCfg = mkCfg(2, 1); riseDly = 0;
    enable = 1'b1;
    waitCyc(1);
    chk(lowStart == 1'b1 && sclOut == 1'b0, "R8 fresh low on re-enable",
        int'({lowStart, sclOut}), 2);
    waitCyc(300);
    chk(lastLow == lowTicks(2) * 2, "R8 low after restart", lastLow, lowTicks(2) * 2);
    chk(lastHigh == highTicks(2) * 2, "R4 high after restart", lastHigh, highTicks(2) * 2);

    finish();
  end
endmodule